// File: doc/BRIEF.md
# Width-Switchable Accumulator and Index Register File

This block holds the working registers of a processor core that can run its accumulator and its index registers at either 8 or 16 bits. The accumulator is stored as two bytes: a visible low byte A and a hidden high byte B. There are also two index registers, X and Y. Two width inputs come from the status unit. One sets the accumulator width and one sets the shared width of both index registers. The core's sequencer issues one operation per cycle: load A, load X, load Y, or swap the two accumulator bytes.

Each register is shaped on its outputs according to the width in force. A width change treats the two register kinds differently:
- Narrowing the index width destroys the high bytes of X and Y.
- The accumulator high byte survives every width change. It stays reachable through the byte swap.

Every load and swap also updates a zero flag and a negative flag, which are measured at the width that applies to the result.

Top module: `dual_width_regs`

## Requirements
- R1: After reset, every stored byte is zero, `acc_o`, `acc_full_o`, `x_o` and `y_o` read zero, and `zero_o` and `neg_o` are 0.
- R2: Load A is `op_i` = 1.
  - With `acc_wide_i` = 1, it stores `data_i[15:8]` in B and `data_i[7:0]` in A.
  - `acc_o` always reads {B,A} when `acc_wide_i` = 1, and {8'h00,A} when it is 0.
- R3: Load A with `acc_wide_i` = 0 writes `data_i[7:0]` into A and leaves B unchanged, as seen on `acc_full_o` = {B,A}.
- R4: A change of `acc_wide_i` alone never alters A or B. After widening, `acc_o` is {B,A}, with B the byte kept while narrow.
- R5: Swap is `op_i` = 4. It exchanges A and B at either accumulator width, and the result is visible the next cycle.
- R6: Load X is `op_i` = 2 and load Y is `op_i` = 3.
  - With `idx_wide_i` = 1, the load stores all 16 bits of `data_i`.
  - With `idx_wide_i` = 0, the load stores `data_i[7:0]` and clears the high byte.
- R7: X and Y share the one width input `idx_wide_i`.
  - With `idx_wide_i` = 0, `x_o` and `y_o` read {8'h00, low byte}.
  - Every clock edge with `idx_wide_i` = 0 clears both stored high bytes, so they read zero after widening again.
- R8: While `idx_wide_i` stays 1 and no index load occurs, X and Y keep all 16 bits. This includes across widening from 8 bits.
- R9: After a load, the flags appear on the next cycle.
  - `zero_o` = 1 when the loaded value is zero at the width in use. Load A uses `acc_wide_i`; load X and load Y use `idx_wide_i`.
  - `neg_o` is bit 15 of the value in 16-bit width and bit 7 in 8-bit width.
- R10: After a swap, `zero_o` and `neg_o` are taken from the new A byte alone (bit 7), whatever the accumulator width.
- R11: `op_i` = 0 and the unused codes 5 to 7 change no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_wide_i | input | 1 | 1 = accumulator is 16 bits, 0 = 8 bits |
| idx_wide_i | input | 1 | 1 = X and Y are 16 bits, 0 = 8 bits |
| op_i | input | 3 | 0 none, 1 load A, 2 load X, 3 load Y, 4 swap A/B |
| data_i | input | 16 | Load value |
| acc_o | output | 16 | Accumulator shaped to the current width |
| acc_full_o | output | 16 | Whole accumulator {B,A} regardless of width |
| x_o | output | 16 | X shaped to the index width |
| y_o | output | 16 | Y shaped to the index width |
| zero_o | output | 1 | Last result was zero at its width |
| neg_o | output | 1 | Sign bit of the last result at its width |

## Verification
The hardest situation to reach from the ports is a register state that depends on a history of width changes. Two examples are a hidden B byte that must survive a narrow load followed by a swap, and an index high byte that must vanish after one narrow cycle and stay gone once wide again. The stimulus starts with directed sequences that fill both bytes at 16 bits, narrow for exactly one cycle, load or swap, and then widen again. It follows with a long stretch where the widths and operations change independently on every cycle. Throughout, a behavioural model tracks the byte history and is compared with the outputs on each clock.

// File: rtl/dual_width_regs_pkg.sv
// Shared constants and operation codes for the width-switchable register file.
package dual_width_regs_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 3'd0,
        OP_LD_A  = 3'd1,
        OP_LD_X  = 3'd2,
        OP_LD_Y  = 3'd3,
        OP_SWAP  = 3'd4
    } reg_op_e;
endpackage

// File: rtl/dwr_acc.sv
// Accumulator storage: visible low byte and hidden high byte.
// Assumes at most one of load/swap is active per cycle; width never changes storage.
module dwr_acc #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          swap,
    input  logic          wide,
    input  logic [2*BW-1:0] d,
    output logic [BW-1:0] lo,
    output logic [BW-1:0] hi
);
    // Update A/B on load or byte swap; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else if (load) begin
            lo <= d[BW-1:0];
            if (wide) hi <= d[2*BW-1:BW];
        end else if (swap) begin
            lo <= hi;
            hi <= lo;
        end
    end
endmodule

// File: rtl/dwr_index.sv
// One index register. High byte is cleared on every edge seen at narrow width,
// and kept while wide. Assumes the shared width input from the status unit.
module dwr_index #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            wide,
    input  logic [2*BW-1:0] d,
    output logic [2*BW-1:0] q
);
    // Load low byte always; high byte from data when wide, else forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (load) q[BW-1:0] <= d[BW-1:0];
            if (!wide)     q[2*BW-1:BW] <= '0;
            else if (load) q[2*BW-1:BW] <= d[2*BW-1:BW];
        end
    end
endmodule

// File: rtl/dwr_flags.sv
// Zero/negative flag register. Evaluates a result at 8 or 16 bits when upd is high.
module dwr_flags #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd,
    input  logic            wide,
    input  logic [2*BW-1:0] val,
    output logic            z,
    output logic            n
);
    logic z_nx;
    logic n_nx;

    // Width-dependent zero test and sign bit selection.
    always_comb begin
        if (wide) begin
            z_nx = (val == '0);
            n_nx = val[2*BW-1];
        end else begin
            z_nx = (val[BW-1:0] == '0);
            n_nx = val[BW-1];
        end
    end

    // Capture the flags of the latest result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z <= 1'b0;
            n <= 1'b0;
        end else if (upd) begin
            z <= z_nx;
            n <= n_nx;
        end
    end
endmodule

// File: rtl/dual_width_regs.sv
// Top of the register file: accumulator (A/B), index registers X and Y, flags.
// Decodes one operation per cycle and shapes outputs to the current widths.
module dual_width_regs
    import dual_width_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wide_i,
    input  logic              idx_wide_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] acc_o,
    output logic [WORD_W-1:0] acc_full_o,
    output logic [WORD_W-1:0] x_o,
    output logic [WORD_W-1:0] y_o,
    output logic              zero_o,
    output logic              neg_o
);
    localparam int NUM_IDX = 2;

    logic [BYTE_W-1:0] a_q;
    logic [BYTE_W-1:0] b_q;
    logic [NUM_IDX-1:0] idx_ld;
    logic [WORD_W-1:0] idx_q [NUM_IDX];
    logic [WORD_W-1:0] idx_sh [NUM_IDX];
    logic ld_a;
    logic do_swap;
    logic f_upd;
    logic f_wide;
    logic [WORD_W-1:0] f_val;

    // Operation decode.
    always_comb begin
        ld_a      = (op_i == OP_LD_A);
        do_swap   = (op_i == OP_SWAP);
        idx_ld[0] = (op_i == OP_LD_X);
        idx_ld[1] = (op_i == OP_LD_Y);
    end

    dwr_acc #(.BW(BYTE_W)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ld_a),
        .swap (do_swap),
        .wide (acc_wide_i),
        .d    (data_i),
        .lo   (a_q),
        .hi   (b_q)
    );

    for (genvar gi = 0; gi < NUM_IDX; gi++) begin : g_idx
        dwr_index #(.BW(BYTE_W)) u_idx (
            .clk  (clk),
            .rst_n(rst_n),
            .load (idx_ld[gi]),
            .wide (idx_wide_i),
            .d    (data_i),
            .q    (idx_q[gi])
        );
        assign idx_sh[gi] = idx_wide_i ? idx_q[gi] : {{BYTE_W{1'b0}}, idx_q[gi][BYTE_W-1:0]};
    end

    // Select the result and width the flags are measured on.
    always_comb begin
        f_upd  = ld_a | do_swap | (|idx_ld);
        f_wide = 1'b0;
        f_val  = data_i;
        if (ld_a) begin
            f_wide = acc_wide_i;
        end else if (|idx_ld) begin
            f_wide = idx_wide_i;
        end else if (do_swap) begin
            f_val  = {{BYTE_W{1'b0}}, b_q};
        end
    end

    dwr_flags #(.BW(BYTE_W)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .upd  (f_upd),
        .wide (f_wide),
        .val  (f_val),
        .z    (zero_o),
        .n    (neg_o)
    );

    // Output shaping to the widths in force.
    always_comb begin
        acc_full_o = {b_q, a_q};
        acc_o      = acc_wide_i ? {b_q, a_q} : {{BYTE_W{1'b0}}, a_q};
        x_o        = idx_sh[0];
        y_o        = idx_sh[1];
    end
endmodule

// File: rtl/dual_width_regs_chk.sv
// Property checker for dual_width_regs, attached with bind below.
module dual_width_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_wide_i,
    input logic        idx_wide_i,
    input logic [2:0]  op_i,
    input logic [15:0] data_i,
    input logic [15:0] acc_o,
    input logic [15:0] acc_full_o,
    input logic [15:0] x_o,
    input logic [15:0] y_o,
    input logic        zero_o,
    input logic        neg_o
);
    a_r3_narrow_load_keeps_b: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 && !acc_wide_i) |=> acc_full_o[15:8] == $past(acc_full_o[15:8]));

    a_r5_swap_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |=> acc_full_o == {$past(acc_full_o[7:0]), $past(acc_full_o[15:8])});

    a_r7_widen_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wide_i) |=> (x_o[15:8] == 8'h00 && y_o[15:8] == 8'h00));

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 || op_i > 3'd4) |=> ($stable(acc_full_o) && $stable(zero_o) && $stable(neg_o)));

    a_r4_width_only_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 3'd1 && op_i != 3'd4) |=> $stable(acc_full_o));

    a_r10_swap_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |=> (zero_o == (acc_full_o[7:0] == 8'h00) && neg_o == acc_full_o[7]));
endmodule

bind dual_width_regs dual_width_regs_chk u_chk (.*);

// File: tb/dual_width_regs_tb.sv
`timescale 1ns/1ps
module dual_width_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wide_i = 1'b0;
    logic        idx_wide_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [15:0] data_i = 16'h0;
    logic [15:0] acc_o, acc_full_o, x_o, y_o;
    logic        zero_o, neg_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // behavioural model state
    int ma = 0, mb = 0, mx = 0, my = 0;
    bit mz = 0, mn = 0;
    bit caw = 0, ciw = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    dual_width_regs u_dut (
        .clk(clk), .rst_n(rst_n), .acc_wide_i(acc_wide_i), .idx_wide_i(idx_wide_i),
        .op_i(op_i), .data_i(data_i), .acc_o(acc_o), .acc_full_o(acc_full_o),
        .x_o(x_o), .y_o(y_o), .zero_o(zero_o), .neg_o(neg_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // compare all outputs against the model (called away from the rising edge)
    task automatic compare();
        int eacc, ex, ey;
        eacc = caw ? (mb * 256 + ma) : ma;
        ex = ciw ? mx : (mx & 255);
        ey = ciw ? my : (my & 255);
        chk(cur_req, "acc_o", int'(acc_o), eacc);
        chk(cur_req, "acc_full_o", int'(acc_full_o), mb * 256 + ma);
        chk(cur_req, "x_o", int'(x_o), ex);
        chk(cur_req, "y_o", int'(y_o), ey);
        chk(cur_req, "zero_o", int'(zero_o), int'(mz));
        chk(cur_req, "neg_o", int'(neg_o), int'(mn));
    endtask

    function automatic void set_flags(int v, bit w);
        if (w) begin
            mz = (v & 16'hFFFF) == 0;
            mn = ((v >> 15) & 1) == 1;
        end else begin
            mz = (v & 255) == 0;
            mn = ((v >> 7) & 1) == 1;
        end
    endfunction

    // apply one cycle of stimulus at the falling edge, update the model, check next falling edge
    task automatic step(int op, int d, bit aw, bit iw, string req);
        int t;
        op_i = 3'(op); data_i = 16'(d); acc_wide_i = aw; idx_wide_i = iw;
        caw = aw; ciw = iw; cur_req = req;
        case (op)
            1: begin
                ma = d & 255;
                if (aw) mb = (d >> 8) & 255;
                set_flags(d, aw);
            end
            2: begin mx = iw ? (d & 16'hFFFF) : (d & 255); set_flags(d, iw); end
            3: begin my = iw ? (d & 16'hFFFF) : (d & 255); set_flags(d, iw); end
            4: begin t = ma; ma = mb; mb = t; set_flags(ma, 1'b0); end
            default: ;
        endcase
        if (!iw) begin mx = mx & 255; my = my & 255; end
        @(negedge clk);
        compare();
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        compare();                                   // R1 reset state
        step(0, 16'h1234, 1, 1, "R1");

        step(1, 16'h8001, 1, 1, "R2");               // R2 wide load, N from bit 15
        step(0, 0, 0, 1, "R2");                      // R2 narrow view {00,A}
        step(1, 16'h5500, 0, 1, "R3");               // R3 narrow load, B kept, Z on low byte
        step(0, 0, 1, 1, "R4");                      // R4 widen shows {B,A}
        step(0, 0, 0, 1, "R4");
        step(0, 0, 1, 1, "R4");
        step(4, 0, 0, 1, "R5");                      // R5 swap at 8 bits
        step(4, 0, 1, 1, "R10");                     // R10 flags from new A
        step(1, 16'h00FF, 1, 1, "R9");               // R9 wide: not negative, not zero
        step(1, 16'h0080, 0, 1, "R9");               // R9 narrow: negative
        step(1, 16'h0000, 1, 1, "R9");               // R9 zero
        step(1, 16'h1200, 1, 1, "R10");
        step(4, 0, 1, 1, "R10");                     // new A = 12 -> not zero
        step(4, 0, 0, 1, "R10");                     // new A = 00 -> zero despite B

        step(2, 16'hABCD, 1, 1, "R6");               // R6 wide X load
        step(3, 16'hF00F, 1, 1, "R6");
        step(0, 0, 1, 1, "R8");                      // R8 held
        step(0, 0, 1, 0, "R7");                      // R7 one narrow cycle
        step(0, 0, 1, 1, "R7");                      // highs gone
        step(3, 16'h9981, 1, 0, "R6");               // R6 narrow load
        step(2, 16'h1234, 1, 1, "R8");
        step(0, 0, 1, 0, "R7");
        step(0, 0, 1, 1, "R8");

        step(5, 16'hFFFF, 0, 0, "R11");
        step(6, 16'h0000, 1, 1, "R11");
        step(7, 16'h8888, 1, 1, "R11");
        step(0, 16'h0000, 1, 1, "R11");

        for (int i = 0; i < 2000; i++) begin
            int op, d;
            op = int'($urandom_range(0, 7));
            d  = int'($urandom_range(0, 65535));
            if (($urandom_range(0, 3)) == 0) d = d & 16'hFF00;
            step(op, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R9");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule